// File: doc/BRIEF.md
# Sine Table Streamer for an I2C 12-bit DAC

This block is an I2C bus master that keeps a 12-bit DAC playing a periodic sine wave with no processor involvement. It walks through a lookup table that holds one period of the wave. For each entry it sends one complete three-byte write frame: START, device address with the write bit, high code byte, low code byte, then STOP. When a STOP finishes, the next START begins on the same bus quarter-tick. The waveform update rate therefore depends only on the SCL speed and the fixed frame length. It does not depend on the table size.

The table length can be 16, 32 or 64 points. The output frequency is the update rate divided by that length. SCL comes from a divider of the system clock, with a fast rate and a standard rate selected by one input. SDA and SCL are open drain: the block only ever pulls a line low or lets it float. The block checks the acknowledge after every byte. On a NACK it closes the frame with a STOP, raises a sticky error and stops streaming until `enable` is dropped.

Top module: `dac_wave_streamer`

## Requirements
- R1: After reset, both bus lines are released and `busy`, `sample_stb` and `nack_err` are low.
- R2: The code sent for table entry k of an M-entry table is round(2048 + 2000·sin(2πk/M)).
- R3: `tbl_sel` selects the table length: 0 gives 16 entries, 1 gives 32, and 2 or 3 give 64. The entry index moves from M-1 back to 0. Each time streaming starts after `enable` was low while the block was idle, the first frame carries entry 0.
- R4: Every frame is START, address byte, first data byte, second data byte, STOP. The address byte is `dev_addr` in bits 7:1 with a 0 write bit in bit 0.
- R5: The first data byte has bits 7:4 equal to zero and carries code bits 11:8 in bits 3:0. The second data byte carries code bits 7:0.
- R6: SDA changes while SCL is high only to form a START (falling) or a STOP (rising). No START appears inside a frame.
- R7: One frame lasts exactly 116 quarter-ticks. With `std_mode` = 0 a quarter-tick is FAST_Q clocks, and with `std_mode` = 1 it is STD_Q clocks. While streaming, `sample_stb` repeats every 116·Q clocks whatever the table length.
- R8: `sample_stb` is high for one clock once per completed frame, when its STOP ends, and the table index advances on it.
- R9: If a byte is not acknowledged (SDA high during the ninth clock), the frame ends with a STOP and no `sample_stb`. `nack_err` is set and stays set, and `busy` stays low, as long as `enable` is high. Taking `enable` low clears `nack_err`.
- R10: If `enable` falls during a frame, that frame completes normally, including its `sample_stb`, and then the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Stream while high; low clears the error and rewinds the table when idle |
| std_mode | input | 1 | 0 selects the fast SCL rate, 1 the standard rate |
| dev_addr | input | 7 | 7-bit DAC bus address |
| tbl_sel | input | 2 | Table length select (16 / 32 / 64) |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A frame is in progress |
| sample_stb | output | 1 | One-clock pulse at the end of each completed frame |
| nack_err | output | 1 | Sticky flag for a missing acknowledge |

## Verification
The bench models the DAC by decoding the bus lines. It compares every frame against a sine computed independently with floating-point math, and it runs enough frames at each table length to pass the wrap. A design with a wrong quarter-wave mirror or a wrong sign fold would send codes that are off in one half or one quadrant. A design with an off-by-one wrap would skip or repeat entry 0. The bench measures the strobe spacing in both speed modes and with different table lengths. A table-dependent delay or a miscounted bit phase would change that spacing.

Further directed cases target the enable and error paths. The bench drops `enable` in the middle of a frame, where a block that aborts the frame would leave a truncated frame on the bus. It injects a NACK on the address byte, where a block that retried or kept streaming would produce more strobes or raise `busy` again. It then recovers by toggling `enable`, where a block that failed to rewind would not restart at entry 0.

// File: rtl/dac_stream_pkg.sv
package dac_stream_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS, ST_STOP} bus_state_e;

  localparam int CODE_W   = 12;
  localparam int IDX_W    = 6;
  localparam int FRAME_W  = 24;
  localparam logic [CODE_W-1:0] MID_CODE = 12'd2048;

  // magnitude of 2000*sin(2*pi*o/64), o = 0..16, rounded
  function automatic logic [10:0] quarter_mag(input logic [4:0] o);
    case (o)
      5'd0:  quarter_mag = 11'd0;
      5'd1:  quarter_mag = 11'd196;
      5'd2:  quarter_mag = 11'd390;
      5'd3:  quarter_mag = 11'd581;
      5'd4:  quarter_mag = 11'd765;
      5'd5:  quarter_mag = 11'd943;
      5'd6:  quarter_mag = 11'd1111;
      5'd7:  quarter_mag = 11'd1269;
      5'd8:  quarter_mag = 11'd1414;
      5'd9:  quarter_mag = 11'd1546;
      5'd10: quarter_mag = 11'd1663;
      5'd11: quarter_mag = 11'd1764;
      5'd12: quarter_mag = 11'd1848;
      5'd13: quarter_mag = 11'd1914;
      5'd14: quarter_mag = 11'd1962;
      5'd15: quarter_mag = 11'd1990;
      default: quarter_mag = 11'd2000;
    endcase
  endfunction

  // code for phase p on a 64-point grid, folded from one quarter wave
  function automatic logic [CODE_W-1:0] wave_code(input logic [IDX_W-1:0] p);
    logic [4:0]  o;
    logic [10:0] a;
    o = p[4] ? (5'd16 - {1'b0, p[3:0]}) : {1'b0, p[3:0]};
    a = quarter_mag(o);
    wave_code = p[5] ? (MID_CODE - {1'b0, a}) : (MID_CODE + {1'b0, a});
  endfunction

  function automatic logic [IDX_W-1:0] tbl_last(input logic [1:0] sel);
    case (sel)
      2'd0:    tbl_last = 6'd15;
      2'd1:    tbl_last = 6'd31;
      default: tbl_last = 6'd63;
    endcase
  endfunction

  function automatic logic [1:0] tbl_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    tbl_shift = 2'd2;
      2'd1:    tbl_shift = 2'd1;
      default: tbl_shift = 2'd0;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] frame_bytes(input logic [6:0] addr,
                                                     input logic [CODE_W-1:0] code);
    frame_bytes = {addr, 1'b0, 4'b0000, code[11:8], code[7:0]};
  endfunction

endpackage

// File: rtl/scl_quarter_div.sv
module scl_quarter_div #(
  parameter int FAST_Q = 125,
  parameter int STD_Q  = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic std_mode,
  output logic tick
);
  localparam int MAXQ = (FAST_Q > STD_Q) ? FAST_Q : STD_Q;
  localparam int CW   = (MAXQ > 1) ? $clog2(MAXQ) : 1;
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_Q - 1);
  localparam logic [CW-1:0] STD_LIM  = CW'(STD_Q - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = std_mode ? STD_LIM : FAST_LIM;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wave_index_ctr.sv
module wave_index_ctr
  import dac_stream_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [1:0]       tbl_sel,
  output logic [IDX_W-1:0] phase
);
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last;
  logic             at_wrap;

  assign last    = tbl_last(tbl_sel);
  assign at_wrap = (idx >= last);
  assign phase   = idx << tbl_shift(tbl_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clear)   idx <= '0;
    else if (advance) idx <= at_wrap ? '0 : idx + 1'b1;
  end

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && idx == last) |=> (idx == '0));
endmodule

// File: rtl/i2c_frame_engine.sv
module i2c_frame_engine
  import dac_stream_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               enable,
  input  logic               sda_in,
  input  logic [FRAME_W-1:0] payload,
  output logic               scl_low,
  output logic               sda_low,
  output logic               busy,
  output logic               frame_done,
  output logic               nack_err
);
  bus_state_e         st;
  logic [1:0]         ph;
  logic [3:0]         bitn;
  logic [1:0]         byten;
  logic [FRAME_W-1:0] shreg;
  logic               ack_bad;
  logic               aborting;
  logic               in_start, in_stop, ack_slot, ph_last;

  assign in_start = (st == ST_START);
  assign in_stop  = (st == ST_STOP);
  assign ack_slot = (st == ST_BITS) && (bitn == 4'd8);
  assign ph_last  = (ph == 2'd3);
  assign busy     = (st != ST_IDLE);

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (st)
      ST_START: begin
        scl_low = ph[1];
        sda_low = (ph != 2'd0);
      end
      ST_BITS: begin
        scl_low = (ph == 2'd0) || (ph == 2'd3);
        sda_low = !ack_slot && !shreg[FRAME_W-1];
      end
      ST_STOP: begin
        scl_low = (ph == 2'd0);
        sda_low = (ph < 2'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bitn <= '0; byten <= '0; shreg <= '0;
      ack_bad <= 1'b0; aborting <= 1'b0; frame_done <= 1'b0; nack_err <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!enable) nack_err <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: if (enable && !nack_err) begin
            st <= ST_START; ph <= '0;
          end
          ST_START: begin
            ph <= ph + 1'b1;
            if (ph == 2'd1) shreg <= payload;   // index has settled by now
            if (ph_last) begin
              st <= ST_BITS; bitn <= '0; byten <= '0;
            end
          end
          ST_BITS: begin
            ph <= ph + 1'b1;
            if (ph == 2'd2 && ack_slot) ack_bad <= sda_in;
            if (ph_last) begin
              if (ack_slot) begin
                bitn <= '0;
                if (ack_bad) begin
                  st <= ST_STOP; aborting <= 1'b1; nack_err <= 1'b1;
                end else if (byten == 2'd2) begin
                  st <= ST_STOP;
                end else begin
                  byten <= byten + 1'b1;
                end
              end else begin
                bitn  <= bitn + 1'b1;
                shreg <= shreg << 1;
              end
            end
          end
          default: begin
            ph <= ph + 1'b1;
            if (ph_last) begin
              frame_done <= !aborting;
              aborting   <= 1'b0;
              st <= (enable && !nack_err && !aborting) ? ST_START : ST_IDLE;
            end
          end
        endcase
      end
    end
  end

  assert_sda_quiet_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_low) && !scl_low && (sda_low != $past(sda_low))) |-> (in_start || in_stop));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_err && enable) |=> nack_err);

  assert_halt_after_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_err && enable && !busy) |=> !busy);

  assert_done_follows_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(in_stop));
endmodule

// File: rtl/dac_wave_streamer.sv
module dac_wave_streamer
  import dac_stream_pkg::*;
#(
  parameter int FAST_Q = 125,
  parameter int STD_Q  = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       std_mode,
  input  logic [6:0] dev_addr,
  input  logic [1:0] tbl_sel,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  output logic       busy,
  output logic       sample_stb,
  output logic       nack_err
);
  logic               tick;
  logic               frame_done;
  logic [IDX_W-1:0]   phase;
  logic [CODE_W-1:0]  code;
  logic [FRAME_W-1:0] payload;
  logic               rewind;

  assign code       = wave_code(phase);
  assign payload    = frame_bytes(dev_addr, code);
  assign rewind     = !enable && !busy;
  assign sample_stb = frame_done;

  scl_quarter_div #(.FAST_Q(FAST_Q), .STD_Q(STD_Q)) u_div (
    .clk(clk), .rst_n(rst_n), .std_mode(std_mode), .tick(tick)
  );

  wave_index_ctr u_idx (
    .clk(clk), .rst_n(rst_n), .clear(rewind), .advance(frame_done),
    .tbl_sel(tbl_sel), .phase(phase)
  );

  i2c_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .sda_in(sda_in),
    .payload(payload), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .busy(busy), .frame_done(frame_done), .nack_err(nack_err)
  );

  assert_stb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
endmodule

// File: tb/dac_wave_streamer_tb.sv
module dac_wave_streamer_tb;
  localparam int FQ = 3;
  localparam int SQ = 6;
  localparam int FRAME_Q = 116;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic std_mode = 1'b0;
  logic [6:0] dev_addr = 7'h60;
  logic [1:0] tbl_sel = 2'd0;
  logic scl_drive_low, sda_drive_low, busy, sample_stb, nack_err;
  logic slv_ack = 1'b0;
  logic sda_line, scl_line;

  assign sda_line = !(sda_drive_low || slv_ack);
  assign scl_line = !scl_drive_low;

  always #2.5 clk = ~clk;

  dac_wave_streamer #(.FAST_Q(FQ), .STD_Q(SQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .std_mode(std_mode),
    .dev_addr(dev_addr), .tbl_sel(tbl_sel), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .busy(busy), .sample_stb(sample_stb), .nack_err(nack_err)
  );

  int nchk = 0;
  int nbad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_code(int k, int m);
    real v;
    v = 2048.0 + 2000.0 * $sin(2.0 * 3.14159265358979 * real'(k) / real'(m));
    return $rtoi(v + 0.5);
  endfunction

  function automatic int len_of(logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 32 : 64;
  endfunction

  // ---------------- slave model ----------------
  int exp_idx = 0;
  int cur_m = 16;
  int frames_ok = 0;
  int aborted = 0;
  bit nack_req = 0;
  bit nack_given = 0;
  bit in_frame = 0;
  int bitc = 0;
  int bytec = 0;
  logic [7:0] sh;
  logic [7:0] rx [3];
  logic prev_scl = 1'b1;
  logic prev_sda = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (scl_line && prev_scl && prev_sda && !sda_line) begin
        chk(!in_frame, "R6 START inside frame", bytec, 0);
        in_frame = 1; bitc = 0; bytec = 0;
      end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
        in_frame = 0;
        if (bytec == 3) begin
          chk(rx[0] == {dev_addr, 1'b0}, "R4 address byte", rx[0], {dev_addr, 1'b0});
          chk(rx[1][7:4] == 4'd0, "R5 upper nibble", rx[1][7:4], 0);
          chk({rx[1][3:0], rx[2]} == exp_code(exp_idx, cur_m), "R2 code",
              {rx[1][3:0], rx[2]}, exp_code(exp_idx, cur_m));
          exp_idx = (exp_idx + 1) % cur_m;   // R3 wrap
          frames_ok++;
        end else begin
          chk(nack_given, "R4 short frame without NACK", bytec, 3);
          nack_given = 0;
          aborted++;
        end
      end else if (scl_line && !prev_scl && in_frame) begin
        if (bitc < 8) sh = {sh[6:0], sda_line};
        bitc++;
        if (bitc == 9) begin
          if (bytec < 3) rx[bytec] = sh;
          bytec++; bitc = 0;
        end
      end else if (!scl_line && prev_scl && in_frame) begin
        if (bitc == 8) begin
          if (nack_req && bytec == 0) begin
            slv_ack = 0; nack_req = 0; nack_given = 1;
          end else slv_ack = 1;
        end else slv_ack = 0;
      end
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // ---------------- strobe monitor ----------------
  int stb_cnt = 0;
  int last_stb = 0;
  bit gap_valid = 0;
  int run_q = FQ;
  logic prev_stb = 1'b0;

  always @(negedge clk) begin
    if (rst_n && sample_stb) begin
      stb_cnt++;
      chk(!prev_stb, "R8 strobe width", 2, 1);
      chk(stb_cnt == frames_ok, "R8 strobe per frame", stb_cnt, frames_ok);
      if (gap_valid)
        chk(cyc - last_stb == FRAME_Q * run_q, "R7 strobe spacing", cyc - last_stb, FRAME_Q * run_q);
      last_stb = cyc;
      gap_valid = 1;
    end
    prev_stb = sample_stb;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, "R10 idle after disable", busy, 0);
  endtask

  task automatic stream(input logic [1:0] sel, input logic sm, input logic [6:0] a, input int nfr);
    int target;
    tbl_sel = sel; std_mode = sm; dev_addr = a;
    cur_m = len_of(sel); run_q = sm ? SQ : FQ;
    exp_idx = 0; gap_valid = 0;
    repeat (2) @(negedge clk);
    target = frames_ok + nfr;
    enable = 1'b1;
    while (frames_ok < target) @(negedge clk);
    repeat (40) @(negedge clk);           // drop enable inside the next frame
    chk(busy, "R10 frame in flight at disable", busy, 1);
    enable = 1'b0;
    wait_idle();
    repeat (4 * SQ + 4) @(negedge clk);
    chk(!in_frame, "R10 last frame completed", in_frame, 0);
    chk(stb_cnt == frames_ok, "R8 strobes match frames", stb_cnt, frames_ok);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low, "R1 lines released", {scl_drive_low, sda_drive_low}, 0);
    chk(!busy && !sample_stb && !nack_err, "R1 status low", {busy, sample_stb, nack_err}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!busy && scl_line && sda_line, "R1 idle after reset", busy, 0);

    stream(2'd0, 1'b0, 7'h60, 20);        // R3 16-entry wrap
    stream(2'd2, 1'b0, 7'h61, 66);        // R3 64-entry wrap
    stream(2'd1, 1'b1, 7'h0F, 34);        // R7 standard rate, 32 entries
    stream(2'd3, 1'b0, 7'h7F, 12);        // R3 select 3 behaves as 64
    for (int i = 0; i < 3; i++) begin
      r = $urandom;
      stream(r[1:0], r[2], r[9:3], 4 + int'(r[13:10] % 12));
    end

    // R9 NACK on the address byte
    tbl_sel = 2'd0; std_mode = 1'b0; dev_addr = 7'h62; cur_m = 16; run_q = FQ;
    exp_idx = 0; gap_valid = 0;
    begin
      int base;
      int stb_at_err;
      int n;
      base = frames_ok;
      enable = 1'b1;
      while (frames_ok < base + 3) @(negedge clk);
      nack_req = 1;
      n = 0;
      while (!nack_err && n < 3000) begin @(negedge clk); n++; end
      chk(nack_err, "R9 error raised", nack_err, 1);
      stb_at_err = stb_cnt;
      n = 0;
      while (busy && n < 3000) begin @(negedge clk); n++; end
      repeat (2000) @(negedge clk);
      chk(!busy, "R9 streaming halted", busy, 0);
      chk(nack_err, "R9 error sticky", nack_err, 1);
      chk(stb_cnt == stb_at_err, "R9 no strobe after NACK", stb_cnt, stb_at_err);
      chk(aborted == 1, "R9 aborted frame closed by STOP", aborted, 1);
      enable = 1'b0;
      repeat (4) @(negedge clk);
      chk(!nack_err, "R9 error cleared by enable low", nack_err, 0);
    end
    stream(2'd0, 1'b0, 7'h62, 5);         // R3 restart from entry 0

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule